// File: doc/BRIEF.md
# Byte-Wide Data Store with Pointer-Based Indirect Access

This block is the 256-byte register and data space of a small accumulator-based core. One address port serves both reads and writes. The low 32 locations are special registers and locations 0x20 to 0xFF are general-purpose storage. Reads are combinational. Whole-byte writes and single-bit set or clear operations take effect on the rising clock edge.

Two locations have no storage of their own. An access to 0x00 is steered to the location named by the pointer byte at 0x01. An access to 0x02 is steered through the pointer byte at 0x03. Location 0x06 holds the low byte of the program counter. Any store that lands there, whether direct or through a pointer, produces a one-cycle strobe that carries the stored byte, so the core can jump within its current 256-word page.

Top module: `ind_data_mem`

## Requirements
- R1: A write with `wr_en`=1 to an address other than 0x00 and 0x02 stores `wr_data` at that address on the rising edge. `rd_data` shows the stored byte combinationally for the address presented.
- R2: An access to address 0x00 reads and writes the location whose address is the current content of location 0x01. For example, with 0x01 holding 0x60, writing 0x31 to 0x00 leaves 0x60 holding 0x31.
- R3: An access to address 0x02 reads and writes the location whose address is the current content of location 0x03.
- R4: When an access to 0x00 or 0x02 resolves through its pointer to 0x00 or 0x02, it reads as 0x00, and its writes and bit operations change no location.
- R5: With `bit_en`=1 and `wr_en`=0, the location's bit number `bit_sel` (0 = LSB) becomes `bit_val` on the edge, and the other seven bits keep their values. When `wr_en`=1, the whole-byte write takes priority over the bit operation.
- R6: A bit operation on address 0x00 or 0x02 first resolves the pointer, then modifies the location the pointer names.
- R7: A store to resolved address 0x06 drives `pcl_wr`=1 for exactly the cycle after the edge, with `pcl_byte` equal to the byte stored. `pcl_wr` is 0 after any cycle without such a store.
- R8: While `rst_n`=0, locations 0x01, 0x03 and 0x06 clear to 0x00, `pcl_wr` clears to 0 and `pcl_byte` clears to 0x00.
- R9: Location 0x06 reads back the last byte stored in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 8 | Access address |
| wr_en | input | 1 | Whole-byte write enable |
| wr_data | input | 8 | Byte to write |
| bit_en | input | 1 | Single-bit operation enable |
| bit_val | input | 1 | Value given to the selected bit |
| bit_sel | input | 3 | Selected bit number |
| rd_data | output | 8 | Combinational read of the resolved location |
| pcl_wr | output | 1 | One-cycle strobe after a store to 0x06 |
| pcl_byte | output | 8 | Byte last stored to 0x06 |

## Verification
Directed steps cover five cases:
- Plain direct writes.
- Indirect writes through each pointer. Reading the target back directly shows whether the redirection uses the right pointer.
- Set and clear on neighbouring bits. These expose a wrong mask or wrong polarity.
- Pointers aimed at 0x00 and 0x02. These show whether the null case is really inert.
- Stores to 0x06, both direct and through a pointer. These separate the strobe path from ordinary writes.

After the directed steps, a long random stream mixes all operation kinds over a small address set. The stream includes the pointers themselves. In that way a pointer changed by one operation steers the next. A behavioural model predicts `rd_data`, `pcl_wr` and `pcl_byte` for every cycle.

// File: rtl/ind_data_mem.sv
module ind_data_mem #(
  parameter int AW   = 8,
  parameter int DW   = 8,
  parameter int IND0 = 0,
  parameter int PTR0 = 1,
  parameter int IND1 = 2,
  parameter int PTR1 = 3,
  parameter int PCLA = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          bit_en,
  input  logic          bit_val,
  input  logic [$clog2(DW)-1:0] bit_sel,
  output logic [DW-1:0] rd_data,
  output logic          pcl_wr,
  output logic [DW-1:0] pcl_byte
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  wire [AW-1:0] ra = (addr == AW'(IND0)) ? AW'(mem[PTR0]) :
                     (addr == AW'(IND1)) ? AW'(mem[PTR1]) : addr;
  wire          nul = (ra == AW'(IND0)) || (ra == AW'(IND1));
  wire [DW-1:0] cur = mem[ra];
  wire [DW-1:0] msk = DW'(1) << bit_sel;
  wire [DW-1:0] nv  = wr_en ? wr_data : (bit_val ? (cur | msk) : (cur & ~msk));
  wire          commit = (wr_en | bit_en) & ~nul;
  wire          hit_pc = commit && (ra == AW'(PCLA));

  assign rd_data = nul ? '0 : cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem[PTR0] <= '0;
      mem[PTR1] <= '0;
      mem[PCLA] <= '0;
    end else if (commit) begin
      mem[ra] <= nv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcl_wr   <= 1'b0;
      pcl_byte <= '0;
    end else begin
      pcl_wr <= hit_pc;
      if (hit_pc) pcl_byte <= nv;
    end
  end

  assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !nul) |=> mem[$past(ra)] == $past(wr_data));

  assert_bit_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !wr_en && !nul) |=>
      (mem[$past(ra)][$past(bit_sel)] == $past(bit_val)) &&
      ($countones(mem[$past(ra)] ^ $past(rd_data)) <= 1));

  assert_null_inert_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || bit_en) && nul) |=>
      (mem[PTR0] == $past(mem[PTR0])) && (mem[PTR1] == $past(mem[PTR1])) && !pcl_wr);

  assert_pcl_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !nul && ra == AW'(PCLA)) |=> pcl_wr && (pcl_byte == $past(wr_data)));

  assert_pcl_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !((wr_en || bit_en) && ra == AW'(PCLA)) |=> !pcl_wr);
endmodule

// File: tb/ind_data_mem_tb.sv
`timescale 1ns/1ps
module ind_data_mem_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       bit_en = 1'b0;
  logic       bit_val = 1'b0;
  logic [2:0] bit_sel = '0;
  logic [7:0] rd_data;
  logic       pcl_wr;
  logic [7:0] pcl_byte;

  int checks = 0;
  int fails  = 0;

  int  m [256];
  bit  kn [256];
  bit  e_wr = 1'b0;
  int  e_byte = 0;

  always #2.5 clk = ~clk;

  ind_data_mem u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .bit_en(bit_en), .bit_val(bit_val), .bit_sel(bit_sel),
    .rd_data(rd_data), .pcl_wr(pcl_wr), .pcl_byte(pcl_byte)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int resolve(int a);
    if (a == 0) return m[1];
    if (a == 2) return m[3];
    return a;
  endfunction

  task automatic op(int a, bit we, int wd, bit be, bit bv, int bs, string tag);
    int  r;
    bit  nul;
    int  nv;
    @(negedge clk);
    chk("R7 strobe", int'(pcl_wr), int'(e_wr));
    chk("R7 byte", int'(pcl_byte), e_byte);
    addr = 8'(a); wr_en = we; wr_data = 8'(wd);
    bit_en = be; bit_val = bv; bit_sel = 3'(bs);
    #0.5;
    r = resolve(a);
    nul = (r == 0) || (r == 2);
    if (nul) chk({tag, " R4 null read"}, int'(rd_data), 0);
    else if (kn[r]) chk(tag, int'(rd_data), m[r]);
    e_wr = 1'b0;
    if ((we || be) && !nul) begin
      if (we) nv = wd & 255;
      else if (bv) nv = m[r] | (1 << bs);
      else nv = m[r] & ~(1 << bs);
      if (we || kn[r]) begin
        m[r] = nv; kn[r] = 1'b1;
        if (r == 6) begin e_wr = 1'b1; e_byte = nv; end
      end else begin
        kn[r] = 1'b0;
      end
    end
    @(posedge clk);
  endtask

  task automatic rd(int a, string tag);
    op(a, 1'b0, 0, 1'b0, 1'b0, 0, tag);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin m[i] = 0; kn[i] = 1'b0; end
    kn[1] = 1'b1; kn[3] = 1'b1; kn[6] = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 pcl_wr", int'(pcl_wr), 0);
    chk("R8 pcl_byte", int'(pcl_byte), 0);
    rst_n = 1'b1;
    rd(1, "R8 ptr0");
    rd(3, "R8 ptr1");
    rd(6, "R8 pcl loc");

    op(8'h20, 1, 8'h55, 0, 0, 0, "R1");
    op(8'hFF, 1, 8'hA5, 0, 0, 0, "R1");
    rd(8'h20, "R1 readback");
    rd(8'hFF, "R1 readback");

    op(1, 1, 8'h60, 0, 0, 0, "R1 ptr0");
    op(0, 1, 8'h31, 0, 0, 0, "R2");
    rd(8'h60, "R2 target");
    rd(0, "R2 indirect read");
    op(3, 1, 8'h80, 0, 0, 0, "R1 ptr1");
    op(2, 1, 8'h7E, 0, 0, 0, "R3");
    rd(8'h80, "R3 target");
    rd(8'h60, "R3 other untouched");

    op(8'h20, 0, 0, 1, 1, 3, "R5 set");
    op(8'h20, 0, 0, 1, 0, 0, "R5 clear");
    rd(8'h20, "R5 result 5C");
    op(8'h20, 1, 8'h0F, 1, 0, 0, "R5 write priority");
    rd(8'h20, "R5 priority 0F");

    op(0, 0, 0, 1, 1, 7, "R6 indirect set");
    rd(8'h60, "R6 target B1");
    op(2, 0, 0, 1, 0, 7, "R6 indirect clear");
    rd(8'h80, "R6 target 7E");

    op(6, 1, 8'h42, 0, 0, 0, "R7 direct");
    rd(6, "R9 readback");
    rd(6, "R9 hold");
    op(1, 1, 8'h06, 0, 0, 0, "R1 ptr0 to pcl");
    op(0, 0, 0, 1, 1, 0, "R7 indirect bit");
    rd(6, "R9 43");

    op(1, 1, 8'h02, 0, 0, 0, "R1 ptr0 null");
    op(0, 1, 8'h99, 0, 0, 0, "R4 write null");
    rd(1, "R4 ptr0 kept");
    rd(3, "R4 ptr1 kept");
    op(3, 1, 8'h00, 0, 0, 0, "R1 ptr1 null");
    op(2, 0, 0, 1, 1, 4, "R4 bit null");
    rd(1, "R4 ptr0 kept");
    rd(3, "R4 ptr1 kept");

    for (int i = 0; i < 600; i++) begin
      int  pick;
      int  a;
      int  k;
      pick = $urandom_range(0, 7);
      case (pick)
        0: a = 0;
        1: a = 1;
        2: a = 2;
        3: a = 3;
        4: a = 6;
        default: a = 8'h20 + $urandom_range(0, 3);
      endcase
      k = $urandom_range(0, 2);
      if (a == 1 || a == 3)
        op(a, 1, ($urandom_range(0, 3) == 0) ? $urandom_range(0, 3) * 2 :
                 (($urandom_range(0, 1) == 1) ? 6 : 8'h20 + $urandom_range(0, 3)),
           0, 0, 0, "R1 sweep ptr");
      else
        op(a, k == 0, $urandom_range(0, 255), k == 1, $urandom_range(0, 1),
           $urandom_range(0, 7), (a == 0) ? "R2 sweep" : (a == 2) ? "R3 sweep" : "R1 sweep");
    end
    rd(6, "R9 final");
    @(negedge clk);
    chk("R7 strobe final", int'(pcl_wr), int'(e_wr));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule